// File: doc/BRIEF.md
# Prefetch Miss Tracking Buffer

This block sits beside a lockup-free primary data cache. It keeps a record of every prefetch that has missed in the cache and is still in flight, so that no line is fetched twice. A prefetch reaches the block together with the cache's hit result from the same cycle. A hit ends the prefetch at once. A miss is compared by line address against every live entry. If a live entry already holds that line, the prefetch is discarded. If no entry holds it and a slot is free, the prefetch takes a new entry. If no entry holds it and every slot is taken, the prefetch is dropped and a one-cycle indicator is raised. The buffer never stalls the requester. An entry holds a line address, a flag that records whether it has gone to a miss handler, and an age rank. It holds no data.

Unsent entries are offered to the miss handling logic oldest first. An entry that cannot be handed over waits in the buffer, and the processor keeps executing. Demand loads probe the buffer in the same way. A load whose line is pending is told which entry to wait on, so it does not start a miss of its own. An entry is freed when the miss handler reports that its fill has completed, not when the data is later used. A completion and a new prefetch in the same cycle are ordered completion first.

Top module: `prefetch_track_buf`

## Requirements
- R1: After reset no entry is live: `full` is 0, `iss_valid` is 0, and no load merges.
- R2: A prefetch with `pf_hit`=1 allocates nothing, drops nothing and changes no state. A later miss to the same line therefore allocates.
- R3: A missing prefetch that matches no live entry, while a slot is free, pulses `pf_alloc` in its request cycle. `pf_alloc_idx` gives the lowest free index.
- R4: A missing prefetch whose line address, with the low LINE_OFF bits ignored, equals a live entry pulses `pf_drop_dup` and changes no state.
- R5: A missing, non-matching prefetch that arrives while all entries are live pulses `pf_drop_full`, allocates nothing and changes no state.
- R6: A load whose line matches a live entry raises `ld_merge` in the same cycle, with that entry's index on `ld_merge_idx`. A load with no match leaves `ld_merge` at 0.
- R7: While any live entry is unsent, `iss_valid` is 1. `iss_idx` and `iss_addr` then give the oldest unsent entry, with the offset bits of `iss_addr` zero. While `iss_ready` is 0 the offer stays the same. When `iss_ready` is 1, that entry is marked sent and the next-oldest unsent entry is offered in the following cycle.
- R8: `done_valid` with `done_idx` frees that entry at the next edge. From the cycle it is raised, the entry no longer matches prefetches or loads.
- R9: If a completion and a prefetch to the completing entry's line arrive in the same cycle, the completion is applied first. The prefetch allocates (it is not a duplicate) and may reuse the freed slot.
- R10: `full` is 1 exactly when every entry is live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_valid | input | 1 | Prefetch request this cycle |
| pf_hit | input | 1 | Prefetch hit in the primary cache this cycle |
| pf_addr | input | ADDR_W | Prefetch byte address |
| pf_alloc | output | 1 | Prefetch took a new entry |
| pf_alloc_idx | output | IDX_W | Entry taken by the prefetch |
| pf_drop_dup | output | 1 | Prefetch discarded as a duplicate of a live entry |
| pf_drop_full | output | 1 | Prefetch discarded because the buffer is full |
| ld_valid | input | 1 | Demand load probe this cycle |
| ld_addr | input | ADDR_W | Load byte address |
| ld_merge | output | 1 | Load merges with a pending prefetch |
| ld_merge_idx | output | IDX_W | Entry the load waits on |
| iss_valid | output | 1 | An unsent entry is offered to the miss handler |
| iss_addr | output | ADDR_W | Line address of the offered entry |
| iss_idx | output | IDX_W | Index of the offered entry |
| iss_ready | input | 1 | Miss handler accepts the offer |
| done_valid | input | 1 | Fill completion this cycle |
| done_idx | input | IDX_W | Entry whose fill completed |
| full | output | 1 | All entries live |

## Verification
The bench builds the buffer with four entries, 16-bit addresses and 16-byte lines. With four entries a handful of requests fills the buffer, so the drop-on-full path, the full flag and the reuse of a freed slot are all reached within a short run. Because the lines are short, addresses that differ only in their offset bits are easy to write, and these exercise the duplicate and merge matching. The age ranks are tracked through completions taken out of allocation order. The bench does this to check the oldest-first issue order after the ranks have been compacted.

// File: rtl/prefetch_track_buf.sv
module prefetch_track_buf #(
  parameter int ENTRIES  = 16,
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int TAG_W   = ADDR_W - LINE_OFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pf_valid,
  input  logic              pf_hit,
  input  logic [ADDR_W-1:0] pf_addr,
  output logic              pf_alloc,
  output logic [IDX_W-1:0]  pf_alloc_idx,
  output logic              pf_drop_dup,
  output logic              pf_drop_full,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_merge,
  output logic [IDX_W-1:0]  ld_merge_idx,
  output logic              iss_valid,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [IDX_W-1:0]  iss_idx,
  input  logic              iss_ready,
  input  logic              done_valid,
  input  logic [IDX_W-1:0]  done_idx,
  output logic              full
);

  logic [ENTRIES-1:0] vld, sent, live, done_vec, pf_match, ld_match;
  logic [TAG_W-1:0]   tag [ENTRIES];
  logic [IDX_W-1:0]   age [ENTRIES];
  logic [IDX_W-1:0]   free_idx, best_age, done_age;
  logic [IDX_W:0]     live_cnt;
  logic               done_live, pf_miss;
  logic [TAG_W-1:0]   pf_tag, ld_tag;

  assign pf_tag    = pf_addr[ADDR_W-1:LINE_OFF];
  assign ld_tag    = ld_addr[ADDR_W-1:LINE_OFF];
  assign done_live = done_valid && vld[done_idx];
  assign done_age  = age[done_idx];
  assign live      = vld & ~done_vec;
  assign full      = &vld;
  assign pf_miss   = pf_valid && !pf_hit;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign done_vec[g] = done_live && (done_idx == IDX_W'(g));
      assign pf_match[g] = live[g] && (tag[g] == pf_tag);
      assign ld_match[g] = live[g] && (tag[g] == ld_tag);
    end
  endgenerate

  assign pf_drop_dup  = pf_miss && |pf_match;
  assign pf_alloc     = pf_miss && !(|pf_match) && !(&live);
  assign pf_drop_full = pf_miss && !(|pf_match) && (&live);
  assign pf_alloc_idx = free_idx;
  assign ld_merge     = ld_valid && |ld_match;
  assign iss_addr     = {tag[iss_idx], {LINE_OFF{1'b0}}};

  always_comb begin
    free_idx     = '0;
    ld_merge_idx = '0;
    live_cnt     = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!live[i]) free_idx = IDX_W'(i);
      if (ld_match[i]) ld_merge_idx = IDX_W'(i);
    end
    for (int i = 0; i < ENTRIES; i++)
      live_cnt = live_cnt + {{IDX_W{1'b0}}, live[i]};
  end

  always_comb begin
    iss_valid = 1'b0;
    iss_idx   = '0;
    best_age  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (live[i] && !sent[i] && (!iss_valid || age[i] < best_age)) begin
        iss_valid = 1'b1;
        iss_idx   = IDX_W'(i);
        best_age  = age[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      sent <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag[i] <= '0;
        age[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (done_vec[i])
          vld[i] <= 1'b0;
        else if (done_live && vld[i] && age[i] > done_age)
          age[i] <= age[i] - 1'b1;
        if (iss_valid && iss_ready && iss_idx == IDX_W'(i))
          sent[i] <= 1'b1;
        if (pf_alloc && free_idx == IDX_W'(i)) begin
          vld[i]  <= 1'b1;
          sent[i] <= 1'b0;
          tag[i]  <= pf_tag;
          age[i]  <= live_cnt[IDX_W-1:0];
        end
      end
    end
  end

endmodule

module prefetch_track_buf_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pf_valid,
  input logic             pf_hit,
  input logic             pf_alloc,
  input logic [IDX_W-1:0] pf_alloc_idx,
  input logic             pf_drop_dup,
  input logic             pf_drop_full,
  input logic             ld_valid,
  input logic             ld_merge,
  input logic             iss_valid,
  input logic [IDX_W-1:0] iss_idx,
  input logic             iss_ready,
  input logic             done_valid,
  input logic             full
);

  p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pf_alloc, pf_drop_dup, pf_drop_full}));

  p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_hit) |-> !(pf_alloc || pf_drop_dup || pf_drop_full));

  p_drop_needs_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pf_drop_full |-> full);

  p_no_alloc_when_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !done_valid) |-> !pf_alloc);

  p_merge_needs_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_merge |-> ld_valid);

  p_sent_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=>
      (!iss_valid || iss_idx != $past(iss_idx) ||
       ($past(pf_alloc) && $past(pf_alloc_idx) == iss_idx)));

  p_hold_offer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready && !done_valid) |=> (iss_valid && $stable(iss_idx)) ||
      ($past(pf_alloc) && 1'b0));

  p_empty_after_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!full && !iss_valid && !ld_merge) || !rst_n);

endmodule

bind prefetch_track_buf prefetch_track_buf_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pf_valid(pf_valid), .pf_hit(pf_hit),
  .pf_alloc(pf_alloc), .pf_alloc_idx(pf_alloc_idx), .pf_drop_dup(pf_drop_dup),
  .pf_drop_full(pf_drop_full), .ld_valid(ld_valid), .ld_merge(ld_merge),
  .iss_valid(iss_valid), .iss_idx(iss_idx), .iss_ready(iss_ready),
  .done_valid(done_valid), .full(full)
);

// File: tb/prefetch_track_buf_tb.sv
`timescale 1ns/1ps
module prefetch_track_buf_tb;
  localparam int EN = 4, AW = 16, LO = 4, IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pf_valid = 0, pf_hit = 0, ld_valid = 0, iss_ready = 0, done_valid = 0;
  logic [AW-1:0] pf_addr = '0, ld_addr = '0;
  logic [IW-1:0] done_idx = '0;
  logic pf_alloc, pf_drop_dup, pf_drop_full, ld_merge, iss_valid, full;
  logic [IW-1:0] pf_alloc_idx, ld_merge_idx, iss_idx;
  logic [AW-1:0] iss_addr;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  prefetch_track_buf #(.ENTRIES(EN), .ADDR_W(AW), .LINE_OFF(LO)) u_dut (.*);

  typedef struct packed {
    logic pv; logic ph; logic [15:0] pa;
    logic lv; logic [15:0] la;
    logic ir; logic dv; logic [1:0] di;
    logic e_alloc; logic [1:0] e_aidx; logic e_dup; logic e_fdrop;
    logic e_merge; logic [1:0] e_midx;
    logic e_iv; logic [1:0] e_iidx; logic [15:0] e_iaddr;
    logic e_full;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{1,0,16'h1000, 0,16'h0000, 0,0,2'd0, 1,2'd0,0,0, 0,2'd0, 0,2'd0,16'h0000, 0},
    '{1,0,16'h1008, 0,16'h0000, 0,0,2'd0, 0,2'd0,1,0, 0,2'd0, 1,2'd0,16'h1000, 0},
    '{1,1,16'h2000, 0,16'h0000, 0,0,2'd0, 0,2'd0,0,0, 0,2'd0, 1,2'd0,16'h1000, 0},
    '{1,0,16'h2000, 1,16'h100C, 1,0,2'd0, 1,2'd1,0,0, 1,2'd0, 1,2'd0,16'h1000, 0},
    '{1,0,16'h3000, 1,16'h4000, 0,0,2'd0, 1,2'd2,0,0, 0,2'd0, 1,2'd1,16'h2000, 0},
    '{1,0,16'h4000, 0,16'h0000, 1,0,2'd0, 1,2'd3,0,0, 0,2'd0, 1,2'd1,16'h2000, 0},
    '{1,0,16'h5000, 1,16'h300F, 0,0,2'd0, 0,2'd0,0,1, 1,2'd2, 1,2'd2,16'h3000, 1},
    '{1,0,16'h2004, 0,16'h0000, 0,1,2'd1, 1,2'd1,0,0, 0,2'd0, 1,2'd2,16'h3000, 1},
    '{0,0,16'h0000, 1,16'h1000, 1,1,2'd0, 0,2'd0,0,0, 0,2'd0, 1,2'd2,16'h3000, 1},
    '{1,0,16'h1000, 0,16'h0000, 1,0,2'd0, 1,2'd0,0,0, 0,2'd0, 1,2'd3,16'h4000, 0},
    '{0,0,16'h0000, 1,16'h2001, 0,0,2'd0, 0,2'd0,0,0, 1,2'd1, 1,2'd1,16'h2000, 1}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    pf_valid = 0; pf_hit = 0; ld_valid = 0; iss_ready = 0; done_valid = 0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "full", full, 0);
    chk("R1", "iss_valid", iss_valid, 0);
    rst_n = 1;

    for (int k = 0; k < 11; k++) begin
      @(negedge clk);
      pf_valid = VECS[k].pv; pf_hit = VECS[k].ph; pf_addr = VECS[k].pa;
      ld_valid = VECS[k].lv; ld_addr = VECS[k].la; iss_ready = VECS[k].ir;
      done_valid = VECS[k].dv; done_idx = VECS[k].di;
      #1;
      chk("R3", $sformatf("v%0d pf_alloc", k), pf_alloc, VECS[k].e_alloc);
      if (VECS[k].e_alloc) chk("R3", $sformatf("v%0d alloc_idx", k), pf_alloc_idx, VECS[k].e_aidx);
      chk("R4", $sformatf("v%0d drop_dup", k), pf_drop_dup, VECS[k].e_dup);
      chk("R5", $sformatf("v%0d drop_full", k), pf_drop_full, VECS[k].e_fdrop);
      chk("R6", $sformatf("v%0d ld_merge", k), ld_merge, VECS[k].e_merge);
      if (VECS[k].e_merge) chk("R6", $sformatf("v%0d merge_idx", k), ld_merge_idx, VECS[k].e_midx);
      chk("R7", $sformatf("v%0d iss_valid", k), iss_valid, VECS[k].e_iv);
      if (VECS[k].e_iv) begin
        chk("R7", $sformatf("v%0d iss_idx", k), iss_idx, VECS[k].e_iidx);
        chk("R7", $sformatf("v%0d iss_addr", k), iss_addr, VECS[k].e_iaddr);
      end
      chk("R10", $sformatf("v%0d full", k), full, VECS[k].e_full);
    end

    // R2: a hit while full and matching nothing is neither dropped nor allocated
    @(negedge clk); idle(); pf_valid = 1; pf_hit = 1; pf_addr = 16'h7000; #1;
    chk("R2", "hit when full alloc", pf_alloc, 0);
    chk("R2", "hit when full drop", pf_drop_full, 0);

    // R8: completion frees the entry; its line no longer merges
    @(negedge clk); idle(); done_valid = 1; done_idx = 2'd2; ld_valid = 1; ld_addr = 16'h3000; #1;
    chk("R8", "merge during completion", ld_merge, 0);
    @(negedge clk); idle(); #1;
    chk("R8", "full after free", full, 0);
    // R9: freed slot reused by lowest-index allocation
    pf_valid = 1; pf_addr = 16'h3004; #0.5;
    chk("R9", "realloc", pf_alloc, 1);
    chk("R9", "realloc idx", pf_alloc_idx, 2);

    // R1: reset mid-run empties the buffer
    @(negedge clk); idle(); rst_n = 0;
    @(negedge clk); #1;
    chk("R1", "full after reset", full, 0);
    chk("R1", "iss_valid after reset", iss_valid, 0);
    rst_n = 1; ld_valid = 1; ld_addr = 16'h1000; #0.5;
    chk("R1", "merge after reset", ld_merge, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule